// File: doc/BRIEF.md
# Character Display Bus Access Controller

This block sits on the host side of an asynchronous parallel bus that connects to an intelligent character display module. The host presents one write or read request at a time on a valid/ready handshake. The block turns each request into a sequence of bus phases: address setup, an active window with chip select and a write or read strobe, and a hold and recovery gap. Every phase lasts a whole number of system clock cycles. Each minimum time is a parameter in nanoseconds and is converted to cycles by rounding up to at least one cycle.

At power-up the block pulses the module's reset line. It then refuses every request until a long lockout has elapsed, so that the module can finish its own internal start-up. Read data is sampled at the instant the read strobe is released and is returned with a one-cycle valid pulse. The data bus is split into an output, an input and an output enable; the enable is high only while a write owns the bus. A variant chosen by parameter drives only writes: the read strobe never asserts, and the select and write strobes move as one.

Top module: `disp_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_ce_n`, `bus_wr_n` and `bus_rd_n` are high, `bus_oe` is low, `bus_rst_n` is low and `req_ready` is low.
- R2: `bus_rst_n` stays low at least 300 ns after `rst_n` rises. No chip select falls earlier than 110 us after `bus_rst_n` rises.
- R3: `bus_addr` is stable at least 10 ns before `bus_ce_n` falls and at least 20 ns after `bus_ce_n` rises. It never changes while `bus_ce_n` is low.
- R4: `bus_ce_n` stays low at least 140 ns for a write and at least 160 ns for a read. The write or read strobe is low only while `bus_ce_n` is low.
- R5: `bus_wr_n` stays low at least 100 ns. The write data on `bus_dout`, with `bus_oe` high, is valid at least 50 ns before `bus_wr_n` rises and is held at least 20 ns after it. The value written equals the request's data.
- R6: Between accesses, `bus_ce_n` stays high at least 60 ns. The time from one fall of `bus_ce_n` to the next is at least 210 ns after a write and at least 230 ns after a read.
- R7: A read returns the value present on `bus_din` when `bus_rd_n` rises, on `rsp_rdata`, with `rsp_valid` high for exactly one cycle. `bus_oe` stays low for at least 10 ns after `bus_rd_n` rises.
- R8: `req_ready` is high only when the block is idle, the lockout is over and recovery has elapsed. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R9: With `WRITE_ONLY` = 1, `req_read` is ignored. Every request becomes a write, `bus_rd_n` never falls and `rsp_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Character or register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DW | Read data |
| bus_addr | output | AW | Address lines to the module |
| bus_dout | output | DW | Data driven toward the module |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | DW | Data returned by the module |
| bus_ce_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rst_n | output | 1 | Module reset, active low |

## Verification
The cycle timing follows from the default parameters at 50 MHz:
- **Read response:** `rsp_valid` and `rsp_rdata` appear in the cycle after the edge that raises `bus_rd_n`.
- **Bus phases:** chip select falls one cycle after a request is taken, and rises 7 cycles later for a write or 8 cycles later for a read.

The bench does not rely on these counts for its timing checks. Monitors record the simulation time of every bus edge and compare each interval with the nanosecond minimums, so a change in rounding is still judged against the real limits. Value checks are sampled on the falling clock edge, after the edge that produces the value: read data at the first such sample where `rsp_valid` is high, and the pulse width at the next sample.

// File: rtl/disp_bus_ctrl.sv
module disp_bus_ctrl #(
  parameter int  AW         = 5,
  parameter int  DW         = 8,
  parameter int  CLK_HZ     = 50_000_000,
  parameter bit  WRITE_ONLY = 1'b0,
  parameter int  T_AS_NS    = 10,
  parameter int  T_AH_NS    = 20,
  parameter int  T_CEW_NS   = 140,
  parameter int  T_CER_NS   = 160,
  parameter int  T_WR_NS    = 100,
  parameter int  T_DS_NS    = 50,
  parameter int  T_DH_NS    = 20,
  parameter int  T_RDA_NS   = 75,
  parameter int  T_DF_NS    = 10,
  parameter int  T_REC_NS   = 60,
  parameter int  T_CYCW_NS  = 210,
  parameter int  T_CYCR_NS  = 230,
  parameter int  T_RST_NS   = 300,
  parameter int  T_LOCK_NS  = 110_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_read,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_ce_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic          bus_rst_n
);

  function automatic int cyc(input longint ns);
    longint c;
    c = (ns * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AS_C   = cyc(T_AS_NS);
  localparam int HOLD_C = mx(cyc(T_AH_NS), cyc(T_DH_NS));
  localparam int ACTW_C = mx(mx(cyc(T_CEW_NS), cyc(T_WR_NS)), cyc(T_DS_NS));
  localparam int ACTR_C = mx(cyc(T_CER_NS), cyc(T_RDA_NS));
  localparam int RECW_C = mx(mx(cyc(T_REC_NS), cyc(T_CYCW_NS) - ACTW_C), HOLD_C);
  localparam int RECR_C = mx(mx(mx(cyc(T_REC_NS), cyc(T_CYCR_NS) - ACTR_C), HOLD_C), cyc(T_DF_NS));
  localparam int RST_C  = cyc(T_RST_NS);
  localparam int LOCK_C = cyc(T_LOCK_NS);

  typedef enum logic [2:0] {S_RST, S_LOCK, S_IDLE, S_SETUP, S_ACT, S_HOLD} state_t;

  state_t state;
  int     cnt;
  int     gap;
  logic   is_rd;

  assign req_ready = (state == S_IDLE) && (gap == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RST;
      cnt       <= 0;
      gap       <= 0;
      is_rd     <= 1'b0;
      bus_rst_n <= 1'b0;
      bus_ce_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_oe    <= 1'b0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (gap != 0) gap <= gap - 1;
      case (state)
        S_RST: begin
          if (cnt == RST_C) begin
            bus_rst_n <= 1'b1;
            cnt       <= 0;
            state     <= S_LOCK;
          end else cnt <= cnt + 1;
        end
        S_LOCK: begin
          if (cnt == LOCK_C - 1) begin
            cnt   <= 0;
            state <= S_IDLE;
          end else cnt <= cnt + 1;
        end
        S_IDLE: begin
          if (req_valid && req_ready) begin
            is_rd    <= req_read && !WRITE_ONLY;
            bus_addr <= req_addr;
            bus_dout <= req_wdata;
            bus_oe   <= !(req_read && !WRITE_ONLY);
            cnt      <= 0;
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (cnt == AS_C - 1) begin
            bus_ce_n <= 1'b0;
            bus_wr_n <= is_rd;
            bus_rd_n <= !is_rd;
            cnt      <= 0;
            state    <= S_ACT;
          end else cnt <= cnt + 1;
        end
        S_ACT: begin
          if (cnt == (is_rd ? ACTR_C : ACTW_C) - 1) begin
            bus_ce_n <= 1'b1;
            bus_wr_n <= 1'b1;
            bus_rd_n <= 1'b1;
            if (is_rd) begin
              rsp_rdata <= bus_din;
              rsp_valid <= 1'b1;
            end
            gap   <= is_rd ? RECR_C : RECW_C;
            cnt   <= 0;
            state <= S_HOLD;
          end else cnt <= cnt + 1;
        end
        S_HOLD: begin
          if (cnt == HOLD_C - 1) begin
            bus_oe <= 1'b0;
            cnt    <= 0;
            state  <= S_IDLE;
          end else cnt <= cnt + 1;
        end
        default: state <= S_RST;
      endcase
    end
  end

endmodule

// File: rtl/disp_bus_ctrl_chk.sv
module disp_bus_ctrl_chk #(
  parameter int AW         = 5,
  parameter bit WRITE_ONLY = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_oe,
  input logic          bus_ce_n,
  input logic          bus_wr_n,
  input logic          bus_rd_n,
  input logic          bus_rst_n
);

  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_addr));

  a_r4_wr_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_ce_n);

  a_r4_rd_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ce_n);

  a_r2_no_ready_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |-> !req_ready);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_ce_n && bus_wr_n && bus_rd_n));

  a_r9_no_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_ONLY != 1'b0) |-> (bus_rd_n && !rsp_valid));

endmodule

bind disp_bus_ctrl disp_bus_ctrl_chk #(.AW(AW), .WRITE_ONLY(WRITE_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_addr(bus_addr), .bus_oe(bus_oe), .bus_ce_n(bus_ce_n), .bus_wr_n(bus_wr_n),
  .bus_rd_n(bus_rd_n), .bus_rst_n(bus_rst_n)
);

// File: tb/disp_bus_ctrl_tb.sv
`timescale 1ns/1ps
module disp_bus_ctrl_tb;
  localparam int AW = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_read = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] bus_din = '0;
  logic          req_ready, rsp_valid, bus_oe, bus_ce_n, bus_wr_n, bus_rd_n, bus_rst_n;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  logic          wo_valid = 1'b0, wo_read = 1'b0;
  logic [AW-1:0] wo_addr = '0;
  logic [DW-1:0] wo_wdata = '0;
  logic          wo_ready, wo_rsp_valid, wo_oe, wo_ce_n, wo_wr_n, wo_rd_n, wo_rst_n;
  logic [DW-1:0] wo_rdata, wo_dout;
  logic [AW-1:0] wo_baddr;

  disp_bus_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_ce_n(bus_ce_n),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_rst_n(bus_rst_n));

  disp_bus_ctrl #(.AW(AW), .DW(DW), .WRITE_ONLY(1'b1)) u_dut_wo (
    .clk(clk), .rst_n(rst_n), .req_valid(wo_valid), .req_ready(wo_ready),
    .req_read(wo_read), .req_addr(wo_addr), .req_wdata(wo_wdata),
    .rsp_valid(wo_rsp_valid), .rsp_rdata(wo_rdata), .bus_addr(wo_baddr),
    .bus_dout(wo_dout), .bus_oe(wo_oe), .bus_din(8'h77), .bus_ce_n(wo_ce_n),
    .bus_wr_n(wo_wr_n), .bus_rd_n(wo_rd_n), .bus_rst_n(wo_rst_n));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return DW'({3'b000, a} * 8'd7 + 8'h11);
  endfunction

  always begin
    @(negedge bus_rd_n);
    bus_din = 8'hEE;
    #75;
    bus_din = mem_val(bus_addr);
    @(posedge bus_rd_n);
    #10;
    bus_din = 8'h00;
  end

  bit  mon_on = 0, have_ce_rise = 0, have_ce_fall = 0, have_wr_rise = 0, have_rd_rise = 0;
  bit  cur_rd = 0, last_rd = 0;
  time t_rel = 0, t_brst = 0, t_ce_fall = 0, t_ce_rise = 0, t_addr = 0;
  time t_wr_fall = 0, t_wr_rise = 0, t_rd_rise = 0, t_dv = 0;
  logic [DW-1:0] last_wdata = '0;

  always @(posedge bus_rst_n) begin
    t_brst = $time;
    chk(t_brst - t_rel >= 300, "R2 reset pulse", longint'(t_brst - t_rel), 300);
  end

  always @(bus_addr) if (mon_on) begin
    chk(bus_ce_n === 1'b1, "R3 addr change under CE", 0, 1);
    if (have_ce_rise) chk($time - t_ce_rise >= 20, "R3 addr hold", longint'($time - t_ce_rise), 20);
    t_addr = $time;
  end

  always @(negedge bus_ce_n) if (mon_on) begin
    chk($time - t_addr >= 10, "R3 addr setup", longint'($time - t_addr), 10);
    chk($time - t_brst >= 110000, "R2 lockout", longint'($time - t_brst), 110000);
    if (have_ce_rise) chk($time - t_ce_rise >= 60, "R6 CE recovery", longint'($time - t_ce_rise), 60);
    if (have_ce_fall)
      chk($time - t_ce_fall >= (last_rd ? 230 : 210), "R6 cycle time",
          longint'($time - t_ce_fall), last_rd ? 230 : 210);
    t_ce_fall = $time;
    have_ce_fall = 1;
  end

  always @(posedge bus_ce_n) if (mon_on && have_ce_fall) begin
    chk($time - t_ce_fall >= (cur_rd ? 160 : 140), "R4 CE width",
        longint'($time - t_ce_fall), cur_rd ? 160 : 140);
    last_rd = cur_rd;
    t_ce_rise = $time;
    have_ce_rise = 1;
  end

  always @(negedge bus_wr_n) if (mon_on) begin
    cur_rd = 0;
    t_wr_fall = $time;
  end

  always @(posedge bus_wr_n) if (mon_on) begin
    chk($time - t_wr_fall >= 100, "R5 WR width", longint'($time - t_wr_fall), 100);
    chk(bus_oe === 1'b1 && $time - t_dv >= 50, "R5 data setup", longint'($time - t_dv), 50);
    last_wdata = bus_dout;
    t_wr_rise = $time;
    have_wr_rise = 1;
  end

  always @(bus_dout) if (mon_on) begin
    if (have_wr_rise) chk($time - t_wr_rise >= 20, "R5 data hold", longint'($time - t_wr_rise), 20);
    t_dv = $time;
  end

  always @(negedge bus_oe) if (mon_on && have_wr_rise)
    chk($time - t_wr_rise >= 20, "R5 OE hold", longint'($time - t_wr_rise), 20);

  always @(posedge bus_oe) if (mon_on) begin
    if (have_rd_rise) chk($time - t_rd_rise >= 10, "R7 float delay", longint'($time - t_rd_rise), 10);
    t_dv = $time;
  end

  always @(negedge bus_rd_n) if (mon_on) cur_rd = 1;
  always @(posedge bus_rd_n) if (mon_on) begin
    t_rd_rise = $time;
    have_rd_rise = 1;
  end

  int wo_rd_falls = 0, wo_wr_falls = 0, wo_rsp = 0;
  logic [DW-1:0] wo_last = '0;
  always @(negedge wo_rd_n) if (mon_on) wo_rd_falls++;
  always @(negedge wo_wr_n) if (mon_on) wo_wr_falls++;
  always @(posedge wo_wr_n) if (mon_on) wo_last = wo_dout;
  always @(posedge clk) if (mon_on && wo_rsp_valid) wo_rsp++;

  task automatic do_req(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready drops after accept", req_ready, 0);
  endtask

  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 5'h03, 8'hA5}, {1'b0, 5'h04, 8'h3C}, {1'b1, 5'h03, 8'h00}, {1'b1, 5'h1F, 8'h00},
    {1'b0, 5'h1F, 8'h00}, {1'b1, 5'h00, 8'h00}, {1'b0, 5'h10, 8'hFF}, {1'b1, 5'h10, 8'h00}};

  initial begin
    #(20 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_ce_n && bus_wr_n && bus_rd_n, "R1 strobes idle in reset", {bus_ce_n, bus_wr_n, bus_rd_n}, 7);
    chk(!bus_oe && !bus_rst_n, "R1 oe/reset line in reset", {bus_oe, bus_rst_n}, 0);
    chk(!req_ready, "R1 ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    t_rel = $time;
    mon_on = 1;
    repeat (100) @(negedge clk);
    chk(!req_ready, "R8 ready low during lockout", req_ready, 0);

    for (int i = 0; i < NV; i++) begin
      logic rd;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {rd, a, d} = VEC[i];
      do_req(rd, a, d);
      if (rd) begin
        int w = 0;
        while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
        chk(rsp_valid && rsp_rdata == mem_val(a), "R7 read data", rsp_rdata, mem_val(a));
        @(negedge clk);
        chk(!rsp_valid, "R7 one-cycle valid", rsp_valid, 0);
      end else begin
        @(posedge bus_ce_n);
        #1;
        chk(last_wdata == d, "R5 written value", last_wdata, d);
      end
    end

    @(negedge clk);
    wo_valid = 1'b1; wo_read = 1'b1; wo_addr = 5'h07; wo_wdata = 8'hC3;
    while (!wo_ready) @(negedge clk);
    @(negedge clk);
    wo_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(wo_rd_falls == 0, "R9 no read strobe", wo_rd_falls, 0);
    chk(wo_wr_falls == 1, "R9 read flag becomes write", wo_wr_falls, 1);
    chk(wo_last == 8'hC3, "R9 write data", wo_last, 8'hC3);
    chk(wo_rsp == 0, "R9 no response", wo_rsp, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule